// File: doc/BRIEF.md
# Host Strobe Qualifier

This block connects a slow host bus that has no clock to a fast synchronous core. The host drives two active-low strobes, one for writes and one for reads, plus a one-bit mode line and an 8-bit data byte. The block first passes each strobe through a short chain of synchronizing flip-flops. A level filter then accepts a change of level only after it has been seen on several core-clock samples in a row. When a strobe becomes qualified, the block captures mode and data in that same cycle and gives the core a single-cycle event pulse.

Each strobe has its own filter state machine with four named states:
- `FLT_IDLE`: the strobe is released.
- `FLT_ARM`: low samples are being counted.
- `FLT_HOLD`: the strobe is accepted as asserted.
- `FLT_REL`: high samples are being counted.

The transitions are:
- **arm**: `FLT_IDLE` to `FLT_ARM` on the first low sample.
- **abort**: `FLT_ARM` to `FLT_IDLE` on any high sample.
- **qualify**: `FLT_ARM` to `FLT_HOLD` when the last required low sample arrives. This transition emits the qualify pulse.
- **release-start**: `FLT_HOLD` to `FLT_REL` on a high sample.
- **reassert**: `FLT_REL` to `FLT_HOLD` on any low sample.
- **release**: `FLT_REL` to `FLT_IDLE` when the last required high sample arrives.

The host gets no wait or ready signal from this block. The host must space its accesses so that each strobe is held long enough to be qualified.

Top module: `host_strobe_qual`

## Requirements
- R1: While reset is high, and in the first cycle after it, `wr_evt_o`, `rd_evt_o` and `err_o` are 0 and `evt_mode_o` and `evt_data_o` are 0.
- R2: `wr_n_i` is active-low (0 = asserted). It is qualified after `FILT_LEN` (default 8) consecutive low samples taken after a `SYNC_STAGES` (default 2) flip-flop synchronizer. If `wr_n_i` goes low just before clock edge k, `wr_evt_o` is high in the cycle that follows edge k+9.
- R3: `rd_n_i` is active-low and is qualified the same way as `wr_n_i`. A clean read strobe produces exactly one `rd_evt_o` pulse.
- R4: A low run shorter than 8 core cycles on either strobe produces no event.
- R5: Each event pulse lasts exactly one core cycle, however long the strobe stays low.
- R6: Once a strobe is asserted, a high run shorter than 8 cycles does not release it, so no second event follows. After at least 8 consecutive high samples, a new low run of at least 8 samples produces a new event.
- R7: On a write event, `evt_data_o` holds the value `data_i` had in the cycle the write qualified. Later changes to `data_i` do not alter `evt_data_o` until the next write event.
- R8: On either event, `evt_mode_o` holds the value `mode_i` had in the cycle the strobe qualified.
- R9: If both strobes qualify in the same cycle, neither event is emitted. In that case `err_o` goes to 1 and stays at 1 until reset.
- R10: A read event leaves `evt_data_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n_i | input | 1 | Host write strobe, active-low, asynchronous |
| rd_n_i | input | 1 | Host read strobe, active-low, asynchronous |
| mode_i | input | 1 | Host mode select, sampled at qualification |
| data_i | input | 8 | Host data byte, sampled at write qualification |
| wr_evt_o | output | 1 | One-cycle write event |
| rd_evt_o | output | 1 | One-cycle read event |
| evt_mode_o | output | 1 | Mode captured with the latest event |
| evt_data_o | output | 8 | Data byte captured with the latest write |
| err_o | output | 1 | Sticky flag: both strobes qualified together |

## Verification
The assertions check the following on every cycle:
- Write and read events never occur together, and an event never lasts two cycles.
- The captured byte shown with a write equals the bus value of the qualifying cycle.
- The error flag never falls outside reset, and the filter counters stay in range.

Only the bench scenarios can show the behaviours that depend on the length of a strobe's history:
- The exact ten-cycle latency.
- That glitches of random length below eight cycles never produce an event.
- That hysteresis holds the strobe through short high gaps.
- That late bus changes leave the captured byte unchanged.

// File: rtl/hsq_pkg.sv
package hsq_pkg;

    // State of one strobe level filter
    typedef enum logic [1:0] {
        FLT_IDLE = 2'd0,  // released
        FLT_ARM  = 2'd1,  // counting low samples
        FLT_HOLD = 2'd2,  // accepted as asserted
        FLT_REL  = 2'd3   // counting high samples
    } flt_state_e;

endpackage

// File: rtl/hsq_sync.sv
module hsq_sync #(
    parameter int STAGES   = 2,
    parameter bit IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{IDLE_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hsq_filter.sv
module hsq_filter
    import hsq_pkg::*;
#(
    parameter int FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_n_i,   // synchronized strobe, active-low
    output logic qual_o     // one-cycle pulse on the qualify transition
);
    localparam int CNT_W = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

    flt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FLT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        qual_o  = 1'b0;
        unique case (state_q)
            FLT_IDLE: begin
                if (!lvl_n_i) begin
                    state_d = FLT_ARM;
                    cnt_d   = CNT_W'(1);
                end
            end
            FLT_ARM: begin
                if (lvl_n_i) begin
                    state_d = FLT_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = FLT_HOLD;
                    cnt_d   = '0;
                    qual_o  = 1'b1;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            FLT_HOLD: begin
                if (lvl_n_i) begin
                    state_d = FLT_REL;
                    cnt_d   = CNT_W'(1);
                end
            end
            FLT_REL: begin
                if (!lvl_n_i) begin
                    state_d = FLT_HOLD;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = FLT_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_d = FLT_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // R5
    qual_single_chk: assert property (@(posedge clk) disable iff (rst)
        qual_o |=> !qual_o);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_LAST);

    // R6
    hold_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == FLT_HOLD && $past(state_q) != FLT_HOLD) |->
            ($past(state_q) == FLT_ARM || $past(state_q) == FLT_REL));
endmodule

// File: rtl/host_strobe_qual.sv
module host_strobe_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 8,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n_i,
    input  logic              rd_n_i,
    input  logic              mode_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              wr_evt_o,
    output logic              rd_evt_o,
    output logic              evt_mode_o,
    output logic [DATA_W-1:0] evt_data_o,
    output logic              err_o
);
    localparam int N_STB = 2;   // index 0 = write, 1 = read

    logic [N_STB-1:0] raw_n;
    logic [N_STB-1:0] sync_n;
    logic [N_STB-1:0] qual;

    assign raw_n = {rd_n_i, wr_n_i};

    for (genvar g = 0; g < N_STB; g++) begin : g_strobe
        hsq_sync #(
            .STAGES   (SYNC_STAGES),
            .IDLE_VAL (1'b1)
        ) sync_i (
            .clk     (clk),
            .rst     (rst),
            .async_i (raw_n[g]),
            .sync_o  (sync_n[g])
        );

        hsq_filter #(
            .FILT_LEN (FILT_LEN)
        ) filt_i (
            .clk     (clk),
            .rst     (rst),
            .lvl_n_i (sync_n[g]),
            .qual_o  (qual[g])
        );
    end

    logic wr_only, rd_only, both;
    assign wr_only = qual[0] & ~qual[1];
    assign rd_only = qual[1] & ~qual[0];
    assign both    = qual[0] & qual[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_evt_o   <= 1'b0;
            rd_evt_o   <= 1'b0;
            evt_mode_o <= 1'b0;
            evt_data_o <= '0;
            err_o      <= 1'b0;
        end else begin
            wr_evt_o <= wr_only;
            rd_evt_o <= rd_only;
            if (wr_only || rd_only) evt_mode_o <= mode_i;
            if (wr_only)            evt_data_o <= data_i;
            if (both)               err_o      <= 1'b1;
        end
    end

    // R9
    no_dual_evt_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_evt_o && rd_evt_o));

    // R5
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_evt_o |=> !wr_evt_o);

    // R5
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_evt_o |=> !rd_evt_o);

    // R7
    wr_data_chk: assert property (@(posedge clk) disable iff (rst)
        wr_evt_o |-> (evt_data_o == $past(data_i)));

    // R8
    mode_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_evt_o || rd_evt_o) |-> (evt_mode_o == $past(mode_i)));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    // R10
    rd_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_evt_o && !$past(wr_evt_o)) |-> $stable(evt_data_o));
endmodule

// File: tb/host_strobe_qual_tb.sv
module host_strobe_qual_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       mode = 1'b0;
    logic [7:0] data = 8'h00;
    logic       wr_evt, rd_evt, evt_mode, err;
    logic [7:0] evt_data;

    int checks = 0;
    int fails  = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int cycles = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    host_strobe_qual dut_i (
        .clk        (clk),
        .rst        (rst),
        .wr_n_i     (wr_n),
        .rd_n_i     (rd_n),
        .mode_i     (mode),
        .data_i     (data),
        .wr_evt_o   (wr_evt),
        .rd_evt_o   (rd_evt),
        .evt_mode_o (evt_mode),
        .evt_data_o (evt_data),
        .err_o      (err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_evt) wr_cnt++;
            if (rd_evt) rd_cnt++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_n = 1'b1; rd_n = 1'b1;
        idle(3);
        rst = 1'b0;
        wr_cnt = 0; rd_cnt = 0;
    endtask

    task automatic test_reset();
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        check("R1 wr_evt", wr_evt, 0);
        check("R1 rd_evt", rd_evt, 0);
        check("R1 err", err, 0);
        check("R1 mode", evt_mode, 0);
        check("R1 data", evt_data, 0);
        rst = 1'b0;
        idle(1);
        check("R1 post wr_evt", wr_evt, 0);
        check("R1 post data", evt_data, 0);
        wr_cnt = 0; rd_cnt = 0;
    endtask

    // R2 R5 exact latency and single pulse
    task automatic test_wr_latency();
        data = 8'hA5; mode = 1'b1;
        wr_n = 1'b0;
        for (int i = 1; i <= 11; i++) begin
            @(negedge clk);
            check("R2 latency", wr_evt, (i == 10) ? 1 : 0);
        end
        idle(20);
        check("R5 single wr pulse", wr_cnt, 1);
        check("R7 data", evt_data, 8'hA5);
        check("R8 mode wr", evt_mode, 1);
        wr_n = 1'b1;
        idle(12);
    endtask

    // R3 R8 R10
    task automatic test_read();
        wr_cnt = 0; rd_cnt = 0;
        mode = 1'b0; data = 8'h3C;
        rd_n = 1'b0;
        idle(30);
        rd_n = 1'b1;
        idle(12);
        check("R3 rd count", rd_cnt, 1);
        check("R3 no wr", wr_cnt, 0);
        check("R8 mode rd", evt_mode, 0);
        check("R10 data kept", evt_data, 8'hA5);
    endtask

    // R7 late bus change ignored
    task automatic test_data_hold();
        wr_cnt = 0;
        data = 8'h5A; mode = 1'b1;
        wr_n = 1'b0;
        idle(14);
        data = 8'hFF; mode = 1'b0;
        idle(10);
        wr_n = 1'b1;
        idle(12);
        check("R7 one wr", wr_cnt, 1);
        check("R7 latched data", evt_data, 8'h5A);
        check("R8 latched mode", evt_mode, 1);
    endtask

    // R4 random glitches
    task automatic test_glitches();
        wr_cnt = 0; rd_cnt = 0;
        for (int i = 0; i < 300; i++) begin
            int len = 1 + ($urandom % 7);
            int gap = 1 + ($urandom % 10);
            data = 8'($urandom);
            if (i % 2 == 0) wr_n = 1'b0; else rd_n = 1'b0;
            idle(len);
            wr_n = 1'b1; rd_n = 1'b1;
            idle(gap);
        end
        idle(12);
        check("R4 glitch wr", wr_cnt, 0);
        check("R4 glitch rd", rd_cnt, 0);
        wr_n = 1'b0; idle(7); wr_n = 1'b1; idle(12);
        check("R4 seven low", wr_cnt, 0);
        wr_n = 1'b0; idle(8); wr_n = 1'b1; idle(12);
        check("R2 eight low", wr_cnt, 1);
    endtask

    // R6 hysteresis
    task automatic test_hysteresis();
        wr_cnt = 0;
        wr_n = 1'b0; idle(20);
        wr_n = 1'b1; idle(7);
        wr_n = 1'b0; idle(20);
        wr_n = 1'b1; idle(12);
        check("R6 short gap one event", wr_cnt, 1);
        wr_cnt = 0;
        wr_n = 1'b0; idle(20);
        wr_n = 1'b1; idle(12);
        wr_n = 1'b0; idle(20);
        wr_n = 1'b1; idle(12);
        check("R6 long gap two events", wr_cnt, 2);
    endtask

    // R9 collision
    task automatic test_collision();
        wr_cnt = 0; rd_cnt = 0;
        wr_n = 1'b0; rd_n = 1'b0;
        idle(20);
        wr_n = 1'b1; rd_n = 1'b1;
        idle(12);
        check("R9 no wr", wr_cnt, 0);
        check("R9 no rd", rd_cnt, 0);
        check("R9 err set", err, 1);
        data = 8'h11;
        wr_n = 1'b0; idle(20); wr_n = 1'b1; idle(12);
        check("R9 err sticky", err, 1);
        check("R9 later write", wr_cnt, 1);
        do_reset();
        idle(1);
        check("R9 err cleared", err, 0);
    endtask

    initial begin
        do_reset();
        test_reset();
        test_wr_latency();
        test_read();
        test_data_hold();
        test_glitches();
        test_hysteresis();
        test_collision();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule